// File: doc/BRIEF.md
# Programmable Divided Countdown Timer

This block is a down-counter that measures time in ticks of a shared clock, divided by a selectable power of two. Software loads a start value, picks a divide ratio and a one-shot or repeating mode, and names the interrupt vector to use. Each time the count runs out, the block sends a one-cycle vector raise request to a neighbouring interrupt controller, unless the interrupt is masked.

The block has four 32-bit registers behind a simple write port and a combinational read port. Writing the initial count restarts the countdown. In repeating mode the period is exactly the initial count in ticks, with no drift. A zero initial count parks the timer. A divide code outside the supported set freezes the count.

Top module: `divided_countdown_timer`

## Requirements
- R1: After reset, or during it, the vector entry reads 0x00010000 (masked, one-shot, vector 0), and the initial count, current count and divide code all read 0. irq_req is low.
- R2: Register selects are 0 for the vector entry, 1 for the initial count, 2 for the current count and 3 for the divide code. In the vector entry, bits 7:0 are the vector, bit 16 is the mask and bit 17 selects repeating mode (1 = repeating). The divide code is bits 3:0. All other bits read 0.
- R3: A 7-bit prescaler is cleared by reset and increments every cycle. With a divide code s from 0 to 7, a tick occurs on each edge where the low s prescaler bits are all ones, which is once every 2^s cycles. Each tick lowers a nonzero current count by one.
- R4: Divide codes 8 to 15 produce no ticks, so the current count holds and no raise occurs.
- R5: A write to the initial count stores the value in both the initial count and the current count.
- R6: Software may write the current count directly. A register write overrides a tick in the same cycle.
- R7: While the initial count is 0, the current count does not change except by writes, and no raise occurs.
- R8: In one-shot mode, the count stops at 0 after it expires, and it raises at most once per load.
- R9: In repeating mode, the tick that takes the count from 1 to 0 loads the initial count instead. The period is therefore exactly the initial count in ticks.
- R10: On the tick that takes the count from 1 to 0, irq_req is high for one cycle after that edge and irq_vec carries the vector field. If the mask bit is set, nothing is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select for writes |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Register select for reads |
| rd_data | output | 32 | Read data (combinational) |
| irq_req | output | 1 | One-cycle vector raise request |
| irq_vec | output | 8 | Vector that goes with irq_req |

## Verification
The countdown is run under a set of configurations, each built to separate one behaviour from the others. These are the fastest divide with a short one-shot (stopped before and after expiry), a medium divide in repeating mode (period and reload), a masked one-shot (expiry without a raise), the slowest divide (prescaler tap selection), a zero initial count (idle), an invalid divide code (frozen count), and a repeating count of one (a raise on every tick). For each window, the bench counts ticks from its own edge counter, so an error in tap position, reload value or pulse count gives a different final count or a different number of pulses. Directed cases cover register field masking, the reset state during a run, a direct current-count write ending in a reload, and an exact tick rate over a whole number of divide periods.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

   typedef enum logic [1:0] {
      SEL_VECTOR  = 2'd0,
      SEL_INIT    = 2'd1,
      SEL_CURRENT = 2'd2,
      SEL_DIVIDE  = 2'd3
   } dtmr_sel_e;

   typedef struct packed {
      logic periodic;
      logic masked;
   } dtmr_ctl_t;

endpackage

// File: rtl/dtmr_prescaler.sv
module dtmr_prescaler #(
   parameter int MAX_SHIFT = 7,
   parameter int DIV_W     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_code,
   output logic             tick
);

   logic [MAX_SHIFT:0] tap;

   generate
      if (MAX_SHIFT == 0) begin : g_direct
         assign tap[0] = 1'b1;
      end else begin : g_counted
         logic [MAX_SHIFT-1:0] pre_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pre_q <= '0;
            else        pre_q <= pre_q + 1'b1;
         end

         assign tap[0] = 1'b1;
         for (genvar s = 1; s <= MAX_SHIFT; s++) begin : g_tap
            assign tap[s] = tap[s-1] & pre_q[s-1];
         end
      end
   endgenerate

   // codes above MAX_SHIFT match no tap and so never tick
   always_comb begin
      tick = 1'b0;
      for (int s = 0; s <= MAX_SHIFT; s++) begin
         if (div_code == DIV_W'(s)) tick = tap[s];
      end
   end

endmodule

// File: rtl/dtmr_regs.sv
module dtmr_regs import dtmr_pkg::*; #(
   parameter int DATA_W   = 32,
   parameter int CNT_W    = 32,
   parameter int VEC_W    = 8,
   parameter int DIV_W    = 4,
   parameter int MASK_BIT = 16,
   parameter int MODE_BIT = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  dtmr_sel_e         wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  dtmr_sel_e         rd_sel,
   input  logic [CNT_W-1:0]  init_cnt,
   input  logic [CNT_W-1:0]  cur_cnt,
   output logic [DATA_W-1:0] rd_data,
   output logic [VEC_W-1:0]  vec_cfg,
   output dtmr_ctl_t         ctl,
   output logic [DIV_W-1:0]  div_code
);

   logic unused_wr_bits;
   assign unused_wr_bits = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_cfg      <= '0;
         ctl.masked   <= 1'b1;
         ctl.periodic <= 1'b0;
         div_code     <= '0;
      end else if (wr_en) begin
         case (wr_sel)
            SEL_VECTOR: begin
               vec_cfg      <= wr_data[VEC_W-1:0];
               ctl.masked   <= wr_data[MASK_BIT];
               ctl.periodic <= wr_data[MODE_BIT];
            end
            SEL_DIVIDE: div_code <= wr_data[DIV_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      rd_data = '0;
      case (rd_sel)
         SEL_VECTOR: begin
            rd_data[VEC_W-1:0] = vec_cfg;
            rd_data[MASK_BIT]  = ctl.masked;
            rd_data[MODE_BIT]  = ctl.periodic;
         end
         SEL_INIT:    rd_data[CNT_W-1:0] = init_cnt;
         SEL_CURRENT: rd_data[CNT_W-1:0] = cur_cnt;
         SEL_DIVIDE:  rd_data[DIV_W-1:0] = div_code;
         default: ;
      endcase
   end

endmodule

// File: rtl/dtmr_counter.sv
module dtmr_counter import dtmr_pkg::*; #(
   parameter int CNT_W = 32,
   parameter int VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             ld_init,
   input  logic             ld_cur,
   input  logic [CNT_W-1:0] wr_val,
   input  dtmr_ctl_t        ctl,
   input  logic [VEC_W-1:0] vec_cfg,
   output logic [CNT_W-1:0] init_cnt,
   output logic [CNT_W-1:0] cur_cnt,
   output logic             irq_req,
   output logic [VEC_W-1:0] irq_vec
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic armed;
   logic last_tick;

   assign armed     = tick && (init_cnt != '0) && (cur_cnt != '0);
   assign last_tick = armed && (cur_cnt == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_cnt <= '0;
         cur_cnt  <= '0;
         irq_req  <= 1'b0;
         irq_vec  <= '0;
      end else begin
         irq_req <= 1'b0;
         if (ld_init) begin
            init_cnt <= wr_val;
            cur_cnt  <= wr_val;
         end else if (ld_cur) begin
            cur_cnt <= wr_val;
         end else if (last_tick) begin
            cur_cnt <= ctl.periodic ? init_cnt : '0;
            if (!ctl.masked) begin
               irq_req <= 1'b1;
               irq_vec <= vec_cfg;
            end
         end else if (armed) begin
            cur_cnt <= cur_cnt - ONE;
         end
      end
   end

endmodule

// File: rtl/divided_countdown_timer.sv
module divided_countdown_timer import dtmr_pkg::*; #(
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 32,
   parameter int VEC_W     = 8,
   parameter int DIV_W     = 4,
   parameter int MAX_SHIFT = 7,
   parameter int MASK_BIT  = 16,
   parameter int MODE_BIT  = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq_req,
   output logic [VEC_W-1:0]  irq_vec
);

   generate
      if (CNT_W > DATA_W) begin : g_bad_cnt
         $error("CNT_W must fit in DATA_W");
      end
      if (MASK_BIT >= DATA_W || MODE_BIT >= DATA_W || MASK_BIT == MODE_BIT) begin : g_bad_bits
         $error("mask and mode bits must be distinct and inside DATA_W");
      end
      if (VEC_W > MASK_BIT || VEC_W > MODE_BIT) begin : g_bad_vec
         $error("vector field overlaps mask or mode bit");
      end
      if ((1 << DIV_W) <= MAX_SHIFT || DIV_W > DATA_W) begin : g_bad_div
         $error("DIV_W too narrow for MAX_SHIFT");
      end
   endgenerate

   dtmr_sel_e             wr_sel;
   dtmr_sel_e             rd_sel;
   logic [CNT_W-1:0]      init_cnt;
   logic [CNT_W-1:0]      cur_cnt;
   logic [VEC_W-1:0]      vec_cfg;
   dtmr_ctl_t             ctl;
   logic [DIV_W-1:0]      div_code;
   logic                  tick;
   logic                  ld_init;
   logic                  ld_cur;

   assign wr_sel  = dtmr_sel_e'(wr_addr);
   assign rd_sel  = dtmr_sel_e'(rd_addr);
   assign ld_init = wr_en && (wr_sel == SEL_INIT);
   assign ld_cur  = wr_en && (wr_sel == SEL_CURRENT);

   dtmr_regs #(
      .DATA_W(DATA_W), .CNT_W(CNT_W), .VEC_W(VEC_W), .DIV_W(DIV_W),
      .MASK_BIT(MASK_BIT), .MODE_BIT(MODE_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .init_cnt(init_cnt),
      .cur_cnt(cur_cnt), .rd_data(rd_data), .vec_cfg(vec_cfg),
      .ctl(ctl), .div_code(div_code)
   );

   dtmr_prescaler #(
      .MAX_SHIFT(MAX_SHIFT), .DIV_W(DIV_W)
   ) u_pre (
      .clk(clk), .rst_n(rst_n), .div_code(div_code), .tick(tick)
   );

   dtmr_counter #(
      .CNT_W(CNT_W), .VEC_W(VEC_W)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .ld_init(ld_init),
      .ld_cur(ld_cur), .wr_val(wr_data[CNT_W-1:0]), .ctl(ctl),
      .vec_cfg(vec_cfg), .init_cnt(init_cnt), .cur_cnt(cur_cnt),
      .irq_req(irq_req), .irq_vec(irq_vec)
   );

endmodule

// File: rtl/divided_countdown_timer_chk.sv
module divided_countdown_timer_chk import dtmr_pkg::*; #(
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 32,
   parameter int DIV_W     = 4,
   parameter int MAX_SHIFT = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              irq_req,
   input logic [CNT_W-1:0]  init_cnt,
   input logic [CNT_W-1:0]  cur_cnt,
   input logic [DIV_W-1:0]  div_code,
   input logic              periodic,
   input logic              masked,
   input logic              tick
);

   // R10: a raise only follows an unmasked count of one
   p_raise_from_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> ($past(cur_cnt) == CNT_W'(1) && !$past(masked)));

   // R10: masked entry never raises
   p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      masked |=> !irq_req);

   // R7: zero initial count freezes the current count
   p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (init_cnt == '0 && !wr_en) |=> $stable(cur_cnt));

   // R4: invalid divide code freezes the current count
   p_bad_div_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (div_code > DIV_W'(MAX_SHIFT) && !wr_en) |=> $stable(cur_cnt));

   // R8: an expired count stays at zero
   p_zero_sticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_cnt == '0 && !wr_en) |=> cur_cnt == '0);

   // R9: repeating expiry reloads the initial count
   p_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && periodic && cur_cnt == CNT_W'(1) && init_cnt != '0 && !wr_en)
      |=> cur_cnt == $past(init_cnt));

   // R5: initial count write loads the current count
   p_init_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == SEL_INIT) |=> cur_cnt == $past(wr_data[CNT_W-1:0]));

endmodule

bind divided_countdown_timer divided_countdown_timer_chk #(
   .DATA_W(DATA_W), .CNT_W(CNT_W), .DIV_W(DIV_W), .MAX_SHIFT(MAX_SHIFT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .irq_req(irq_req), .init_cnt(init_cnt),
   .cur_cnt(cur_cnt), .div_code(div_code), .periodic(ctl.periodic),
   .masked(ctl.masked), .tick(tick)
);

// File: tb/divided_countdown_timer_test.sv
`timescale 1ns/1ps
module divided_countdown_timer_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = 2'd0;
   logic [31:0] wr_data = '0;
   logic [1:0]  rd_addr = 2'd0;
   logic [31:0] rd_data;
   logic        irq_req;
   logic [7:0]  irq_vec;

   int checks = 0;
   int errors = 0;
   int unsigned edges = 0;

   always #4 clk = ~clk;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) edges <= 0;
      else        edges <= edges + 1;
   end

   divided_countdown_timer uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .irq_req(irq_req), .irq_vec(irq_vec)
   );

   typedef struct packed {
      logic [3:0]  code;
      logic [31:0] init;
      logic        per;
      logic        mask;
      logic [7:0]  vec;
      logic [15:0] n;
   } row_t;

   localparam int NROWS = 8;
   localparam row_t ROWS [NROWS] = '{
      '{4'd0, 32'd5, 1'b0, 1'b0, 8'h31, 16'd3},
      '{4'd0, 32'd5, 1'b0, 1'b0, 8'h31, 16'd8},
      '{4'd2, 32'd4, 1'b1, 1'b0, 8'h42, 16'd40},
      '{4'd3, 32'd3, 1'b0, 1'b1, 8'h55, 16'd60},
      '{4'd7, 32'd2, 1'b1, 1'b0, 8'h66, 16'd600},
      '{4'd1, 32'd0, 1'b1, 1'b0, 8'h77, 16'd20},
      '{4'd9, 32'd6, 1'b0, 1'b0, 8'h88, 16'd50},
      '{4'd5, 32'd1, 1'b1, 1'b0, 8'h99, 16'd200}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic watch(input int n, output int pulses, output logic [7:0] vec);
      pulses = 0; vec = '0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (irq_req) begin pulses++; vec = irq_vec; end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int          pulses;
      logic [7:0]  pvec;

      repeat (3) @(negedge clk);
      // R1: state during reset
      rd(2'd0, v); check("R1 vector in reset", v, 32'h0001_0000);
      rst_n = 1'b1;
      @(negedge clk);
      rd(2'd0, v); check("R1 vector", v, 32'h0001_0000);
      rd(2'd1, v); check("R1 init", v, 32'h0);
      rd(2'd2, v); check("R1 current", v, 32'h0);
      rd(2'd3, v); check("R1 divide", v, 32'h0);
      check("R1 irq_req", {31'b0, irq_req}, 32'h0);

      // R2: unused bits read zero
      wr(2'd0, 32'hFFFF_FFFF);
      rd(2'd0, v); check("R2 vector fields", v, 32'h0003_00FF);
      wr(2'd3, 32'hFFFF_FFFF);
      rd(2'd3, v); check("R2 divide field", v, 32'h0000_000F);

      // table of configurations
      for (int r = 0; r < NROWS; r++) begin
         row_t        t;
         int unsigned w, ticks, ecur, eirq;
         string       tag;
         t = ROWS[r];
         wr(2'd0, ({31'b0, t.per} << 17) | ({31'b0, t.mask} << 16) | {24'b0, t.vec});
         wr(2'd3, {28'b0, t.code});
         wr(2'd1, t.init);
         w = edges;
         rd(2'd1, v); check("R5 init loaded", v, t.init);
         rd(2'd2, v); check("R5 current loaded", v, t.init);
         watch(int'(t.n), pulses, pvec);
         ticks = 0;
         if (t.code <= 4'd7)
            for (int unsigned e = w + 1; e <= w + t.n; e++)
               if ((e % (32'd1 << t.code)) == 0) ticks++;
         if (t.init == 0 || t.code > 4'd7) begin
            ecur = t.init; eirq = 0;
            tag = (t.code > 4'd7) ? "R4 frozen count" : "R7 idle count";
         end else if (!t.per) begin
            ecur = (ticks >= t.init) ? 0 : t.init - ticks;
            eirq = (ticks >= t.init && !t.mask) ? 1 : 0;
            tag = "R8 one-shot count";
         end else begin
            ecur = ((ticks % t.init) == 0) ? t.init : t.init - (ticks % t.init);
            eirq = t.mask ? 0 : ticks / t.init;
            tag = "R9 repeating count";
         end
         rd(2'd2, v); check(tag, v, ecur);
         check("R10 raise count", pulses, eirq);
         if (eirq > 0) check("R10 raise vector", {24'b0, pvec}, {24'b0, t.vec});
      end

      // R3: exact rate, divide by 8 over 64 cycles
      wr(2'd0, 32'h0001_0000);
      wr(2'd3, 32'd3);
      wr(2'd1, 32'd1000);
      watch(64, pulses, pvec);
      rd(2'd2, v); check("R3 eight ticks in 64 cycles", v, 32'd992);

      // R6: direct current write then R9 reload
      wr(2'd0, 32'h0002_00A5);
      wr(2'd3, 32'd0);
      wr(2'd1, 32'd100);
      wr(2'd2, 32'd3);
      watch(3, pulses, pvec);
      check("R6 raise after direct write", pulses, 1);
      check("R10 vector after direct write", {24'b0, pvec}, 32'h0000_00A5);
      rd(2'd2, v); check("R9 reload value", v, 32'd100);

      // R7: idle with a nonzero current count
      wr(2'd1, 32'd0);
      wr(2'd2, 32'd7);
      watch(20, pulses, pvec);
      rd(2'd2, v); check("R7 current holds while idle", v, 32'd7);
      check("R7 no raise while idle", pulses, 0);

      // R1: reset in the middle of a run
      wr(2'd1, 32'd50);
      repeat (5) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rd(2'd2, v); check("R1 current after reset", v, 32'h0);
      rd(2'd0, v); check("R1 vector after reset", v, 32'h0001_0000);
      rst_n = 1'b1;
      @(negedge clk);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule